// File: doc/BRIEF.md
# Floppy Controller Register Bank

This block is the byte-wide, memory-mapped register file of a floppy disk controller. Sixteen byte registers sit one per 16-byte slot of a small address window. Software uses them to set up seek, sector and format parameters and to drive the controller's command bits. It reads back the drive sense and FIFO status, the track and sector the read path has seen, latched error causes and latched interrupt causes. The disk data path and the drive mechanics sit outside the block. They report events through single-cycle pulse inputs and level inputs, and they take their settings from the register outputs.

The control register has no direct write. A write to the control slot clears every control bit that is 1 in the written byte. A write to the status slot sets those bits instead. The interrupt and error registers latch events and clear themselves when read. A single interrupt line is formed from the latched causes, the enable mask and a master enable bit in control. A down-counting microsecond timer, ticked by a prescaler on the system clock, raises its own interrupt cause when it reaches zero.

The bus is a plain register bus with no handshake. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr` while `bus_rd` is high. The clear-on-read side effects of a read take effect at the edge that ends the read cycle.

Top module: `fdc_regbank`

## Requirements
- R1: After reset, every register reads 0x00 and `irq_o` is low.
- R2: Slot index = address bits [7:4]. Slots 0 data, 3 mode, 4 select, 5 setup, 9 seek count, 12 gap, 13 target sector, 14 sector count and 15 interrupt enable read back the last byte written. An address whose low four bits are not zero reads 0x00, and a write to it is ignored.
- R3: A write to slot 6 clears the control bits that are 1 in the written byte. Slot 6 reads the control register.
- R4: A write to slot 7 sets the control bits that are 1 in the written byte. Control bit 0 is the master interrupt enable.
- R5: The interrupt register (slot 8) latches its causes: bit 5 error, 4 data changed, 3 transfer done, 2 sector seen, 1 seek done, 0 timer done. Pulse inputs `ev_i[4:0]` drive bits 5..1. A read returns the flags and clears them, but a cause arriving in the clearing cycle stays set. Causes latch whether or not they are enabled.
- R6: The error register (slot 2) latches `err_i[3:0]` into bits 7 (data CRC), 6 (address CRC), 2 (overrun) and 0 (underrun). A read clears it.
- R7: `irq_o` is high exactly when control bit 0 is set and the interrupt flags AND the enable mask is nonzero.
- R8: Status (slot 7 read) is, from bit 7 down: FIFO one byte, FIFO two bytes, error register nonzero, 0, drive sense, read data, enabled interrupt pending (independent of control bit 0), mark byte.
- R9: A write to slot 1 loads the timer. It decreases by one every CLK_PER_US clocks counted from the load and stops at zero. The step from 1 to 0 sets interrupt bit 0. Loading zero sets nothing.
- R10: A setup write with bit 7 set clears control, the interrupt flags, the error register and the timer in the same edge. The setup register keeps bits 6:0 and bit 7 always reads 0.
- R11: Slots 10 and 11 read `trk_i` and `sec_i`. Writes to slots 2, 8, 10 and 11 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, acts at the clock edge |
| bus_rd | input | 1 | Read strobe, clear-on-read acts at the clock edge |
| bus_addr | input | 8 | Byte address (REG_SHIFT+4 bits) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when bus_rd is low |
| ev_i | input | 5 | Event pulses for interrupt bits 5..1 |
| err_i | input | 4 | Error pulses for error bits 7, 6, 2, 0 |
| fifo1_i | input | 1 | FIFO holds one byte |
| fifo2_i | input | 1 | FIFO holds two bytes |
| sense_i | input | 1 | Drive sense line |
| rddata_i | input | 1 | Raw read data level |
| mark_i | input | 1 | Mark byte in FIFO |
| trk_i | input | 8 | Current track from read path |
| sec_i | input | 8 | Current sector from read path |
| ctrl_o | output | 8 | Control register |
| mode_o | output | 8 | Mode register |
| sel_o | output | 8 | Drive select register |
| setup_o | output | 8 | Setup register (bit 7 always 0) |
| data_o | output | 8 | Data register |
| nseek_o | output | 8 | Seek count |
| gap_o | output | 8 | Gap length |
| tsect_o | output | 8 | Target sector |
| nsect_o | output | 8 | Sector count |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with CLK_PER_US = 4 and the default REG_SHIFT = 4. A short prescaler lets a three-count timer run to zero within a dozen clocks, so the bench can sample exact tick boundaries. It also makes the timer's done event land on the same edge as an interrupt-register read, which exercises the set-over-clear rule. The default REG_SHIFT keeps the 16-byte slot spacing. The misaligned-address rule can then be probed at offset 0x31.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  typedef logic [7:0] byte_t;

  localparam int SLOT_DATA   = 0;
  localparam int SLOT_TIMER  = 1;
  localparam int SLOT_ERR    = 2;
  localparam int SLOT_MODE   = 3;
  localparam int SLOT_SEL    = 4;
  localparam int SLOT_SETUP  = 5;
  localparam int SLOT_CCLR   = 6;
  localparam int SLOT_CSET   = 7;
  localparam int SLOT_INTR   = 8;
  localparam int SLOT_NSEEK  = 9;
  localparam int SLOT_TRK    = 10;
  localparam int SLOT_SEC    = 11;
  localparam int SLOT_GAP    = 12;
  localparam int SLOT_TSECT  = 13;
  localparam int SLOT_NSECT  = 14;
  localparam int SLOT_IEN    = 15;

  localparam int SETUP_SRST_BIT = 7;
  localparam int CTRL_IEN_BIT   = 0;
  localparam int INTR_W         = 6;
  localparam int ERR_W          = 4;
endpackage

// File: rtl/fdc_tick.sv
module fdc_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST) && !restart_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (restart_i)     cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fdc_downcnt.sv
module fdc_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic [W-1:0] q_o,
  output logic         done_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] q;

  assign q_o    = q;
  assign done_o = tick_i && (q == ONE) && !load_i && !srst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  q <= '0;
    else if (srst_i)             q <= '0;
    else if (load_i)             q <= load_val_i;
    else if (tick_i && q != '0)  q <= q - ONE;
  end
endmodule

// File: rtl/fdc_flagbank.sv
module fdc_flagbank #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst_i,
  input  logic         rdclr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q_o[i] <= 1'b0;
      else if (srst_i)    q_o[i] <= 1'b0;
      else if (set_i[i])  q_o[i] <= 1'b1;
      else if (rdclr_i)   q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/fdc_regbank.sv
module fdc_regbank
  import fdc_pkg::*;
#(
  parameter int REG_SHIFT  = 4,
  parameter int CLK_PER_US = 50,
  localparam int ADDR_W    = REG_SHIFT + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [4:0]        ev_i,
  input  logic [3:0]        err_i,
  input  logic              fifo1_i,
  input  logic              fifo2_i,
  input  logic              sense_i,
  input  logic              rddata_i,
  input  logic              mark_i,
  input  logic [7:0]        trk_i,
  input  logic [7:0]        sec_i,
  output logic [7:0]        ctrl_o,
  output logic [7:0]        mode_o,
  output logic [7:0]        sel_o,
  output logic [7:0]        setup_o,
  output logic [7:0]        data_o,
  output logic [7:0]        nseek_o,
  output logic [7:0]        gap_o,
  output logic [7:0]        tsect_o,
  output logic [7:0]        nsect_o,
  output logic              irq_o
);
  // slot decode
  logic [3:0] slot;
  logic       aligned;
  logic [15:0] wr_hit, rd_hit;

  assign slot    = bus_addr[ADDR_W-1 -: 4];
  assign aligned = (bus_addr[REG_SHIFT-1:0] == '0);

  for (genvar s = 0; s < 16; s++) begin : g_dec
    assign wr_hit[s] = bus_wr && aligned && (slot == 4'(s));
    assign rd_hit[s] = bus_rd && aligned && (slot == 4'(s));
  end

  logic srst;
  assign srst = wr_hit[SLOT_SETUP] && bus_wdata[SETUP_SRST_BIT];

  // plain registers and control aliases
  byte_t data_q, mode_q, sel_q, setup_q, ctrl_q, nseek_q, gap_q, tsect_q, nsect_q, ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0; mode_q  <= '0; sel_q   <= '0; setup_q <= '0; ctrl_q <= '0;
      nseek_q <= '0; gap_q   <= '0; tsect_q <= '0; nsect_q <= '0; ien_q  <= '0;
    end else begin
      if (wr_hit[SLOT_DATA])  data_q  <= bus_wdata;
      if (wr_hit[SLOT_MODE])  mode_q  <= bus_wdata;
      if (wr_hit[SLOT_SEL])   sel_q   <= bus_wdata;
      if (wr_hit[SLOT_SETUP]) setup_q <= {1'b0, bus_wdata[6:0]};
      if (wr_hit[SLOT_NSEEK]) nseek_q <= bus_wdata;
      if (wr_hit[SLOT_GAP])   gap_q   <= bus_wdata;
      if (wr_hit[SLOT_TSECT]) tsect_q <= bus_wdata;
      if (wr_hit[SLOT_NSECT]) nsect_q <= bus_wdata;
      if (wr_hit[SLOT_IEN])   ien_q   <= bus_wdata;
      if (srst)                    ctrl_q <= '0;
      else if (wr_hit[SLOT_CCLR])  ctrl_q <= ctrl_q & ~bus_wdata;
      else if (wr_hit[SLOT_CSET])  ctrl_q <= ctrl_q | bus_wdata;
    end
  end

  // timer
  logic       tick, tdone;
  logic [7:0] timer_q;

  fdc_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (wr_hit[SLOT_TIMER] || srst),
    .tick_o    (tick)
  );

  fdc_downcnt #(.W(8)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .srst_i     (srst),
    .load_i     (wr_hit[SLOT_TIMER]),
    .load_val_i (bus_wdata),
    .tick_i     (tick),
    .q_o        (timer_q),
    .done_o     (tdone)
  );

  // latched interrupt causes and error causes
  logic [INTR_W-1:0] intr_q;
  logic [ERR_W-1:0]  errf_q;

  fdc_flagbank #(.W(INTR_W)) u_intr (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst_i  (srst),
    .rdclr_i (rd_hit[SLOT_INTR]),
    .set_i   ({ev_i, tdone}),
    .q_o     (intr_q)
  );

  fdc_flagbank #(.W(ERR_W)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst_i  (srst),
    .rdclr_i (rd_hit[SLOT_ERR]),
    .set_i   (err_i),
    .q_o     (errf_q)
  );

  byte_t intr_byte, err_byte, status_byte;
  logic  pend;

  assign intr_byte   = {2'b00, intr_q};
  assign err_byte    = {errf_q[3], errf_q[2], 3'b000, errf_q[1], 1'b0, errf_q[0]};
  assign pend        = |(intr_byte & ien_q);
  assign status_byte = {fifo1_i, fifo2_i, |errf_q, 1'b0, sense_i, rddata_i, pend, mark_i};
  assign irq_o       = ctrl_q[CTRL_IEN_BIT] && pend;

  // read mux
  byte_t rmux;
  always_comb begin
    unique case (slot)
      4'(SLOT_DATA):  rmux = data_q;
      4'(SLOT_TIMER): rmux = timer_q;
      4'(SLOT_ERR):   rmux = err_byte;
      4'(SLOT_MODE):  rmux = mode_q;
      4'(SLOT_SEL):   rmux = sel_q;
      4'(SLOT_SETUP): rmux = setup_q;
      4'(SLOT_CCLR):  rmux = ctrl_q;
      4'(SLOT_CSET):  rmux = status_byte;
      4'(SLOT_INTR):  rmux = intr_byte;
      4'(SLOT_NSEEK): rmux = nseek_q;
      4'(SLOT_TRK):   rmux = trk_i;
      4'(SLOT_SEC):   rmux = sec_i;
      4'(SLOT_GAP):   rmux = gap_q;
      4'(SLOT_TSECT): rmux = tsect_q;
      4'(SLOT_NSECT): rmux = nsect_q;
      default:        rmux = ien_q;
    endcase
  end

  assign bus_rdata = (bus_rd && aligned) ? rmux : 8'h00;

  assign ctrl_o  = ctrl_q;
  assign mode_o  = mode_q;
  assign sel_o   = sel_q;
  assign setup_o = setup_q;
  assign data_o  = data_q;
  assign nseek_o = nseek_q;
  assign gap_o   = gap_q;
  assign tsect_o = tsect_q;
  assign nsect_o = nsect_q;
endmodule

// File: rtl/fdc_regbank_chk.sv
module fdc_regbank_chk #(
  parameter int REG_SHIFT = 4,
  localparam int ADDR_W   = REG_SHIFT + 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        ctrl_o,
  input logic              irq_o,
  input logic [5:0]        intr_q,
  input logic [7:0]        timer_q,
  input logic [4:0]        ev_i
);
  logic [3:0] s;
  logic       al, w_clr, w_set, w_tmr, w_srst, r_intr;

  assign s      = bus_addr[ADDR_W-1 -: 4];
  assign al     = (bus_addr[REG_SHIFT-1:0] == '0);
  assign w_clr  = bus_wr && al && s == 4'd6;
  assign w_set  = bus_wr && al && s == 4'd7;
  assign w_tmr  = bus_wr && al && s == 4'd1;
  assign w_srst = bus_wr && al && s == 4'd5 && bus_wdata[7];
  assign r_intr = bus_rd && al && s == 4'd8;

  AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    w_clr |=> (ctrl_o & $past(bus_wdata)) == 8'h00); // R3
  AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    w_set |=> (ctrl_o & $past(bus_wdata)) == $past(bus_wdata)); // R4
  AST_INTR_RDCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (r_intr && ev_i == 5'b0) |=> intr_q[5:1] == 5'b0); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ctrl_o[0]); // R7
  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!w_tmr && !w_srst && timer_q != 8'h00) |=>
      (timer_q == $past(timer_q) || timer_q == $past(timer_q) - 8'd1)); // R9
  AST_TIMER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!w_tmr && timer_q == 8'h00) |=> timer_q == 8'h00); // R9
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    w_srst |=> (ctrl_o == 8'h00 && intr_q == 6'h00 && timer_q == 8'h00)); // R10
endmodule

bind fdc_regbank fdc_regbank_chk #(.REG_SHIFT(REG_SHIFT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .ctrl_o    (ctrl_o),
  .irq_o     (irq_o),
  .intr_q    (intr_q),
  .timer_q   (timer_q),
  .ev_i      (ev_i)
);

// File: tb/sim_fdc_regbank.sv
module sim_fdc_regbank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [4:0] ev_i = '0;
  logic [3:0] err_i = '0;
  logic       fifo1_i = 0, fifo2_i = 0, sense_i = 0, rddata_i = 0, mark_i = 0;
  logic [7:0] trk_i = 8'h21, sec_i = 8'h0C;
  logic [7:0] ctrl_o, mode_o, sel_o, setup_o, data_o, nseek_o, gap_o, tsect_o, nsect_o;
  logic       irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fdc_regbank #(.REG_SHIFT(4), .CLK_PER_US(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_i(ev_i), .err_i(err_i),
    .fifo1_i(fifo1_i), .fifo2_i(fifo2_i), .sense_i(sense_i), .rddata_i(rddata_i),
    .mark_i(mark_i), .trk_i(trk_i), .sec_i(sec_i), .ctrl_o(ctrl_o), .mode_o(mode_o),
    .sel_o(sel_o), .setup_o(setup_o), .data_o(data_o), .nseek_o(nseek_o), .gap_o(gap_o),
    .tsect_o(tsect_o), .nsect_o(nsect_o), .irq_o(irq_o)
  );

  // {address, write data, expected readback, read-only flag}
  localparam logic [24:0] VEC [14] = '{
    {8'h00, 8'hA5, 8'hA5, 1'b0}, {8'h30, 8'h95, 8'h95, 1'b0},
    {8'h40, 8'h0B, 8'h0B, 1'b0}, {8'h50, 8'h28, 8'h28, 1'b0},
    {8'h90, 8'h07, 8'h07, 1'b0}, {8'hC0, 8'h1B, 8'h1B, 1'b0},
    {8'hD0, 8'h09, 8'h09, 1'b0}, {8'hE0, 8'h12, 8'h12, 1'b0},
    {8'hF0, 8'h3F, 8'h3F, 1'b0}, {8'hA0, 8'h55, 8'h21, 1'b1},
    {8'hB0, 8'h66, 8'h0C, 1'b1}, {8'h20, 8'hFF, 8'h00, 1'b1},
    {8'h80, 8'hFF, 8'h00, 1'b1}, {8'h31, 8'h77, 8'h00, 1'b0}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_ev(input logic [4:0] e);
    ev_i = e;
    @(posedge clk); @(negedge clk);
    ev_i = '0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h60, r); check("R1 ctrl", r, 8'h00);
    rd(8'h70, r); check("R1 status", r, 8'h00);
    rd(8'h10, r); check("R1 timer", r, 8'h00);
    check("R1 irq", {7'b0, irq_o}, 8'h00);

    // R2 / R11 table walk
    for (int i = 0; i < 14; i++) begin
      wr(VEC[i][24:17], VEC[i][16:9]);
      rd(VEC[i][24:17], r);
      check(VEC[i][0] ? "R11 readonly" : "R2 readback", r, VEC[i][8:1]);
    end

    // R4 set alias, R3 clear alias
    wr(8'h70, 8'h81); rd(8'h60, r); check("R4 set", r, 8'h81);
    wr(8'h70, 8'h02); check("R4 ctrl_o", ctrl_o, 8'h83);
    wr(8'h60, 8'h80); rd(8'h60, r); check("R3 clear", r, 8'h03);

    // R5 / R7 interrupt latch and gating (ien = 0x3F, ctrl bit0 set)
    pulse_ev(5'b00100);
    check("R7 irq high", {7'b0, irq_o}, 8'h01);
    rd(8'h70, r); check("R8 pending bit", r, 8'h02);
    rd(8'h80, r); check("R5 read flags", r, 8'h08);
    check("R7 irq after clear", {7'b0, irq_o}, 8'h00);
    rd(8'h80, r); check("R5 cleared", r, 8'h00);
    wr(8'hF0, 8'h02);
    pulse_ev(5'b00010);
    check("R7 masked", {7'b0, irq_o}, 8'h00);
    rd(8'h80, r); check("R5 latch when masked", r, 8'h04);
    wr(8'hF0, 8'h3F);
    wr(8'h60, 8'h01);
    pulse_ev(5'b00001);
    check("R7 master off", {7'b0, irq_o}, 8'h00);
    rd(8'h70, r); check("R8 pending no master", r, 8'h02);
    wr(8'h70, 8'h01);
    check("R7 master on", {7'b0, irq_o}, 8'h01);
    rd(8'h80, r); check("R5 seek done", r, 8'h02);

    // R6 error latch
    err_i = 4'hF; @(posedge clk); @(negedge clk); err_i = 4'h0;
    rd(8'h70, r); check("R8 error bit", r, 8'h20);
    rd(8'h20, r); check("R6 error bits", r, 8'hC5);
    rd(8'h20, r); check("R6 cleared", r, 8'h00);

    // R8 status inputs
    fifo1_i = 1; sense_i = 1; mark_i = 1;
    rd(8'h70, r); check("R8 status a", r, 8'h89);
    fifo1_i = 0; sense_i = 0; mark_i = 0; fifo2_i = 1; rddata_i = 1;
    rd(8'h70, r); check("R8 status b", r, 8'h44);
    fifo2_i = 0; rddata_i = 0;

    // R9 timer: load 3, period 4 clocks
    wr(8'h10, 8'h03);
    repeat (4) @(posedge clk); @(negedge clk);
    rd(8'h10, r); check("R9 after one tick", r, 8'h02);
    repeat (6) begin @(posedge clk); @(negedge clk); end
    rd(8'h80, r); check("R9 not yet done", r, 8'h00);
    rd(8'h10, r); check("R9 reached zero", r, 8'h00);
    rd(8'h80, r); check("R9 done survives clear R5", r, 8'h01);
    repeat (10) @(posedge clk); @(negedge clk);
    rd(8'h10, r); check("R9 stays zero", r, 8'h00);
    wr(8'h10, 8'h00);
    repeat (10) @(posedge clk); @(negedge clk);
    rd(8'h80, r); check("R9 zero load no flag", r, 8'h00);

    // R10 soft reset
    wr(8'h70, 8'hFF);
    pulse_ev(5'b11111);
    err_i = 4'hF; @(posedge clk); @(negedge clk); err_i = 4'h0;
    wr(8'h10, 8'hC8);
    wr(8'h50, 8'h83);
    rd(8'h60, r); check("R10 ctrl", r, 8'h00);
    rd(8'h80, r); check("R10 intr", r, 8'h00);
    rd(8'h20, r); check("R10 error", r, 8'h00);
    rd(8'h10, r); check("R10 timer", r, 8'h00);
    rd(8'h50, r); check("R10 setup", r, 8'h03);

    finish_run();
  end
endmodule